// File: doc/BRIEF.md
# Target Read Path Clear and Ready Sequencer

This block takes a synchronous, active-low clear request from user logic on the user clock. It turns that request into a single flush strobe for the target read-data FIFO and the captured-request store. It also drives a ready flag that tells the user logic when normal traffic may resume. Glitches and short pulses on the clear line are filtered out: the clear takes effect only after the line has been seen low on a minimum number of consecutive clock edges.

Once a clear is accepted, ready stays low for as long as the clear is held. After the clear is released, ready stays low for a fixed settling interval. A clear seen again during that interval restarts the sequence. After power-on reset the block runs the same settling interval before it first raises ready.

The block carries no data stream, so it has no valid/ready handshake. The clear input and the ready and flush outputs are plain level and strobe pins with no back-pressure. The flush strobe is a one-cycle pulse that the FIFO and the request store must accept unconditionally. Crossing the strobe into the bus clock domain is done outside this block.

Top module: `tgt_clr_seq`

## Requirements
- R1: `clr_n` is active low and is sampled on each rising edge of `clk`. A low run of fewer than `MIN_CLR` (default 3) consecutive samples does not change `ready_o` and does not raise `flush_o`.
- R2: On the edge that takes the `MIN_CLR`-th consecutive low sample, the clear is accepted and `ready_o` is low right after that edge.
- R3: `flush_o` is high for exactly the one cycle that follows the accepting edge. It pulses once per low run, however long the run lasts.
- R4: `ready_o` stays low on every cycle in which an accepted clear is still held low.
- R5: The first high sample after an accepted clear starts the settling interval. `ready_o` rises right after the edge that comes `SETTLE_CYC` edges later, with `SETTLE_CYC` between 8 and 10 and 9 by default.
- R6: Any low sample during the settling interval restarts it. `ready_o` stays low, and the full `SETTLE_CYC` interval counts again from the next high sample. If that new run reaches `MIN_CLR` samples, it raises one more flush pulse.
- R7: While `rst_n` is low, `ready_o` and `flush_o` are both low. With `clr_n` held high, `ready_o` rises right after the `SETTLE_CYC`-th rising edge following the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User-side clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Active-low clear request, synchronous to `clk` |
| ready_o | output | 1 | High when the target read path may be used |
| flush_o | output | 1 | One-cycle flush strobe to the read-data FIFO and the request store |

## Verification
A wrong run count inside the block shows at the ports within one cycle of the offending edge. Ready drops on a short pulse, or fails to drop after the third low sample, and the flush strobe appears in the wrong cycle or twice. A wrong settling count moves the rising edge of ready by whole cycles relative to the release of the clear. A restart that is missed lets ready rise too early after a clear issued during settling. Each of these shows within `SETTLE_CYC` cycles of the event.

// File: rtl/tgt_clr_pkg.sv
package tgt_clr_pkg;

  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_CLEAR  = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/tgt_clr_qual.sv
module tgt_clr_qual #(
  parameter int MIN_CLR = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic low_smp,
  output logic accept
);

  localparam int RUN_W = $clog2(MIN_CLR + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_CLR);

  logic [RUN_W-1:0] run_q;

  // consecutive low-sample counter, saturating once the clear is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr_n) begin
      run_q <= '0;
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign low_smp = !clr_n;
  assign accept  = !clr_n && (run_q == RUN_MAX - 1'b1);

endmodule

// File: rtl/tgt_settle_timer.sv
module tgt_settle_timer #(
  parameter int SETTLE_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic done
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // reset preloads the interval so power-on follows the same settling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
    end else if (load) begin
      cnt_q <= CNT_INIT;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/tgt_clr_seq.sv
module tgt_clr_seq
  import tgt_clr_pkg::*;
#(
  parameter int MIN_CLR    = 3,
  parameter int SETTLE_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic ready_o,
  output logic flush_o
);

  localparam int CHK_W = $clog2(MIN_CLR + SETTLE_CYC + 2);
  localparam logic [CHK_W-1:0] CHK_SAT = '1;

  logic       low_smp;
  logic       accept;
  logic       tmr_load;
  logic       tmr_tick;
  logic       tmr_done;
  logic       flush_q;
  seq_state_e state_q;
  seq_state_e state_d;

  tgt_clr_qual #(.MIN_CLR(MIN_CLR)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .low_smp (low_smp),
    .accept  (accept)
  );

  tgt_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .tick  (tmr_tick),
    .done  (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_tick = 1'b0;
    unique case (state_q)
      ST_READY: begin
        if (accept) state_d = ST_CLEAR;
      end
      ST_CLEAR: begin
        if (!low_smp) begin
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (low_smp) begin
          state_d = ST_CLEAR;
        end else if (tmr_done) begin
          state_d = ST_READY;
        end else begin
          tmr_tick = 1'b1;
        end
      end
      default: state_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SETTLE;
      flush_q <= 1'b0;
    end else begin
      state_q <= state_d;
      flush_q <= accept;
    end
  end

  assign ready_o = (state_q == ST_READY);
  assign flush_o = flush_q;

  // observation counters for the port-level properties below
  logic [CHK_W-1:0] lo_run;
  logic [CHK_W-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else if (clr_n) begin
      lo_run <= '0;
      hi_run <= (hi_run == CHK_SAT) ? hi_run : hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      lo_run <= (lo_run == CHK_SAT) ? lo_run : lo_run + 1'b1;
    end
  end

  assert_short_run_keeps_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ready_o) && lo_run < CHK_W'(MIN_CLR)) |-> ready_o);

  assert_fall_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> lo_run >= CHK_W'(MIN_CLR));

  assert_flush_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !ready_o);

  assert_flush_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  assert_rise_after_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> hi_run >= CHK_W'(SETTLE_CYC));

endmodule

// File: tb/tgt_clr_seq_test.sv
module tgt_clr_seq_test;

  localparam int MINC   = 3;
  localparam int SETTLE = 9;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic ready;
  logic flush;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tgt_clr_seq #(.MIN_CLR(MINC), .SETTLE_CYC(SETTLE)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .ready_o (ready),
    .flush_o (flush)
  );

  task automatic check(input logic act, input bit exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // single low pulse of length len starting at edge 1, from the ready state
  task automatic pulse_sweep(input int len);
    int last = len + SETTLE + 4;
    for (int n = 1; n <= last; n++) begin
      bit exp_r;
      bit exp_f;
      string tag;
      clr_n = !(n <= len);
      @(negedge clk);
      if (len < MINC) begin
        exp_r = 1'b1;
        exp_f = 1'b0;
        tag   = "R1";
      end else begin
        exp_r = !(n >= MINC && n < len + 1 + SETTLE);
        exp_f = (n == MINC);
        if (n == MINC)     tag = "R2";
        else if (n <= len) tag = "R4";
        else               tag = "R5";
      end
      check(ready, exp_r, tag, $sformatf("ready len=%0d n=%0d", len, n));
      check(flush, exp_f, (len < MINC) ? "R1" : "R3", $sformatf("flush len=%0d n=%0d", len, n));
    end
  endtask

  // accepted clear of MINC samples, release, then a second low run of m
  // samples starting j edges into the settling interval
  task automatic restart_sweep(input int j, input int m);
    int rel2 = MINC + 1 + j + m;
    int last = rel2 + SETTLE + 3;
    for (int n = 1; n <= last; n++) begin
      bit low;
      bit exp_r;
      bit exp_f;
      low = (n <= MINC) || (n >= MINC + 1 + j && n < rel2);
      clr_n = !low;
      @(negedge clk);
      exp_r = !(n >= MINC && n < rel2 + SETTLE);
      exp_f = (n == MINC) || (m >= MINC && n == MINC + j + MINC);
      check(ready, exp_r, "R6", $sformatf("ready j=%0d m=%0d n=%0d", j, m, n));
      check(flush, exp_f, "R6", $sformatf("flush j=%0d m=%0d n=%0d", j, m, n));
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    // R7: reset state and power-on settling
    repeat (3) begin
      @(negedge clk);
      check(ready, 1'b0, "R7", "ready during reset");
      check(flush, 1'b0, "R7", "flush during reset");
    end
    rst_n = 1'b1;
    for (int n = 1; n <= SETTLE + 3; n++) begin
      clr_n = 1'b1;
      @(negedge clk);
      check(ready, n >= SETTLE, "R7", $sformatf("power-on ready n=%0d", n));
      check(flush, 1'b0, "R7", $sformatf("power-on flush n=%0d", n));
    end

    // R1..R5: pulse lengths from glitch to long hold
    for (int len = 1; len <= 7; len++) pulse_sweep(len);

    // R6: restart at every settling offset with short and accepted runs
    for (int j = 1; j < SETTLE; j++) begin
      for (int m = 1; m <= 4; m++) restart_sweep(j, m);
    end

    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

endmodule